// File: doc/BRIEF.md
# Transactional Undo Log Controller

This block sits in front of a small word-addressed data memory and makes stores reversible for several hardware thread contexts. Each thread opens a transaction with a begin strobe and closes it with a commit strobe. While a thread's transaction is open, every store it issues first saves the target word's current value, together with its address, into that thread's own undo log. Only then is the new value written to memory. A commit throws the log away in one cycle and leaves memory as written. An abort can come from a software input or a hardware input. It makes the controller replay the thread's log newest entry first, one memory write per cycle, until every word touched by the transaction holds its value from before the begin. A one-cycle done pulse then tells the surrounding logic that a handler may run.

Stores enter through a valid/ready stream carrying a thread id, an address and data. `st_ready` does not depend on `st_valid`. A store counts as accepted in any cycle where both are high. `st_ready` is low while any thread is rolling back, because rollback writes own the single memory write port. A sender facing back-pressure must hold the store until it is accepted. A combinational read port (`ld_addr`/`ld_data`) shows memory contents. The control and status pins are plain one-bit-per-thread signals.

All strobes and an accepted store are sampled at the same rising edge. Their effect is judged against the state held before that edge.

Top module: `txlog_ctrl`

## Requirements
- R1: A store from a thread with no open transaction writes memory at the accepting edge and is never logged; the new value is visible on `ld_data` after that edge.
- R2: `tx_begin[t]` on a closed, idle thread sets `tx_open[t]` after the edge. `tx_commit[t]` with nesting depth zero clears `tx_open[t]` after the edge, empties the log and leaves memory unchanged.
- R3: A store accepted for a thread with an open transaction and a non-full log appends {address, old word} to that thread's log and writes the new data to memory at the same edge.
- R4: `sw_abort[t]` or `hw_abort[t]` on an open, non-rolling thread sets `rolling[t]` after the edge. One log entry is restored per granted cycle, newest first. When the log is empty, `rolling[t]` and `tx_open[t]` clear together and `abort_done[t]` is high for exactly one cycle.
- R5: Repeated stores to one address within a transaction are each logged, so after an abort that address holds its value from before the begin.
- R6: Each thread has a separate log. Aborting one thread restores only that thread's logged words and leaves another thread's open transaction and its memory updates in place.
- R7: A transactional store arriving when the thread's log already holds DEPTH entries is consumed without writing memory. `overflow[t]` pulses high for one cycle after the edge, and the transaction is forced into rollback (`rolling[t]` high in the same cycle as the pulse).
- R8: While any thread is rolling back, `st_ready` is low and only rollback writes reach memory. When several threads roll back at once, the lowest-numbered thread with log entries left is served first.
- R9: A begin on a thread that is already open increments a nesting depth (saturating at 2^NEST_W-1) instead of opening a new transaction. Each commit at non-zero depth only decrements the depth. An abort at any depth rolls back the whole flattened transaction.
- R10: Begin, commit and abort strobes on a rolling thread are ignored. Commit and abort on a closed thread are ignored. When abort and commit arrive together on an open thread, the abort wins.
- R11: After reset every thread is closed and not rolling, `abort_done` and `overflow` are low, all memory words read zero and `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be accepted (low during any rollback) |
| st_tid | input | TW | Thread issuing the store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_addr | input | AW | Read port address |
| ld_data | output | DW | Combinational read of memory at `ld_addr` |
| tx_begin | input | NTHR | Per-thread begin strobe |
| tx_commit | input | NTHR | Per-thread commit strobe |
| sw_abort | input | NTHR | Per-thread software abort request |
| hw_abort | input | NTHR | Per-thread hardware abort request |
| tx_open | output | NTHR | Thread has an open transaction (including during rollback) |
| rolling | output | NTHR | Thread is replaying its undo log |
| abort_done | output | NTHR | One-cycle pulse when a rollback has finished |
| overflow | output | NTHR | One-cycle pulse when a store hit a full log |

## Verification
A wrong log pointer or a wrong log entry shows up as a wrong word on the read port, at the latest when the rollback that replays it finishes. A missing or extra entry also moves `abort_done` a cycle earlier or later than the count of logged stores predicts. A wrong phase or nesting depth shows on `tx_open`, `rolling` or `st_ready` in the very next cycle after the strobe that should have changed it. The bench sweeps `ld_addr` and compares every status pin against its model on every clock, so a divergence is reported within one cycle of reaching the ports.

// File: rtl/txlog_pkg.sv
package txlog_pkg;
  parameter int unsigned DEF_THREADS = 2;
  parameter int unsigned DEF_AW      = 4;
  parameter int unsigned DEF_DW      = 8;
  parameter int unsigned DEF_DEPTH   = 4;
  parameter int unsigned DEF_NEST_W  = 3;

  // Per-thread transaction phase
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPEN = 2'd1,
    PH_ROLL = 2'd2
  } tx_phase_e;
endpackage

// File: rtl/txlog_mem.sv
module txlog_mem #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] word_q [WORDS];

  // R11: memory clears to zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) word_q[i] <= '0;
    end else if (we) begin
      word_q[waddr] <= wdata;
    end
  end

  assign rdata_a = word_q[raddr_a];
  assign rdata_b = word_q[raddr_b];
endmodule

// File: rtl/txlog_thread.sv
module txlog_thread
  import txlog_pkg::*;
#(
  parameter int unsigned AW     = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned NEST_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             begin_i,
  input  logic             commit_i,
  input  logic             abort_i,
  input  logic             push_i,
  input  logic [AW+DW-1:0] push_entry_i,
  input  logic             pop_i,
  output logic             open_o,
  output logic             rolling_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [AW+DW-1:0] top_o,
  output logic             done_o
);
  localparam int unsigned EW   = AW + DW;
  localparam int unsigned PW   = $clog2(DEPTH + 1);
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned NMAX = (1 << NEST_W) - 1;

  tx_phase_e         ph_q;
  logic [PW-1:0]     ptr_q;
  logic [NEST_W-1:0] nest_q;
  logic              done_q;
  logic [EW-1:0]     log_q [DEPTH];

  logic [IW-1:0] top_idx;
  assign top_idx = IW'(ptr_q - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      ptr_q  <= '0;
      nest_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      // R3: append a before-image entry
      if (push_i) ptr_q <= ptr_q + PW'(1);
      unique case (ph_q)
        PH_ROLL: begin
          // R4: finish when the log is drained, otherwise pop on grant
          if (ptr_q == '0) begin
            ph_q   <= PH_IDLE;
            nest_q <= '0;
            done_q <= 1'b1;
          end else if (pop_i) begin
            ptr_q <= ptr_q - PW'(1);
          end
        end
        PH_OPEN: begin
          if (abort_i) begin
            ph_q <= PH_ROLL;              // R10: abort beats commit
          end else if (commit_i) begin
            if (nest_q != '0) begin
              nest_q <= nest_q - NEST_W'(1);  // R9
            end else begin
              ph_q  <= PH_IDLE;           // R2: discard log in one cycle
              ptr_q <= '0;
            end
          end else if (begin_i && nest_q != NEST_W'(NMAX)) begin
            nest_q <= nest_q + NEST_W'(1);    // R9: flatten nested begin
          end
        end
        default: begin
          if (begin_i) ph_q <= PH_OPEN;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) log_q[IW'(ptr_q)] <= push_entry_i;
  end

  assign open_o    = (ph_q != PH_IDLE);
  assign rolling_o = (ph_q == PH_ROLL);
  assign full_o    = (ptr_q == PW'(DEPTH));
  assign empty_o   = (ptr_q == '0);
  assign top_o     = log_q[top_idx];
  assign done_o    = done_q;
endmodule

// File: rtl/txlog_ctrl.sv
module txlog_ctrl
  import txlog_pkg::*;
#(
  parameter int unsigned NTHR   = DEF_THREADS,
  parameter int unsigned AW     = DEF_AW,
  parameter int unsigned DW     = DEF_DW,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned NEST_W = DEF_NEST_W,
  localparam int unsigned TW    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [TW-1:0]   st_tid,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [AW-1:0]   ld_addr,
  output logic [DW-1:0]   ld_data,
  input  logic [NTHR-1:0] tx_begin,
  input  logic [NTHR-1:0] tx_commit,
  input  logic [NTHR-1:0] sw_abort,
  input  logic [NTHR-1:0] hw_abort,
  output logic [NTHR-1:0] tx_open,
  output logic [NTHR-1:0] rolling,
  output logic [NTHR-1:0] abort_done,
  output logic [NTHR-1:0] overflow
);
  localparam int unsigned EW = AW + DW;

  logic [NTHR-1:0] open_w, roll_w, full_w, empty_w, done_w;
  logic [NTHR-1:0] push_w, pop_w, abort_w, ovf_d, ovf_q;
  logic [EW-1:0]   top_w [NTHR];
  logic [EW-1:0]   rb_entry;
  logic            rb_we, st_we, accept;
  logic [DW-1:0]   old_word;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr;
  logic [DW-1:0]   mem_wdata;

  // R8: rollback owns the write port, stores wait
  assign st_ready = ~(|roll_w);
  assign accept   = st_valid & st_ready;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic tx_store;
    assign tx_store   = accept && (st_tid == TW'(t)) && open_w[t];
    assign push_w[t]  = tx_store && !full_w[t];
    assign ovf_d[t]   = tx_store && full_w[t];           // R7
    assign abort_w[t] = sw_abort[t] | hw_abort[t] | ovf_d[t];

    txlog_thread #(
      .AW(AW), .DW(DW), .DEPTH(DEPTH), .NEST_W(NEST_W)
    ) u_thr (
      .clk          (clk),
      .rst_n        (rst_n),
      .begin_i      (tx_begin[t]),
      .commit_i     (tx_commit[t]),
      .abort_i      (abort_w[t]),
      .push_i       (push_w[t]),
      .push_entry_i ({st_addr, old_word}),
      .pop_i        (pop_w[t]),
      .open_o       (open_w[t]),
      .rolling_o    (roll_w[t]),
      .full_o       (full_w[t]),
      .empty_o      (empty_w[t]),
      .top_o        (top_w[t]),
      .done_o       (done_w[t])
    );
  end

  // R8: lowest-numbered rolling thread with entries left gets the port
  always_comb begin
    pop_w    = '0;
    rb_we    = 1'b0;
    rb_entry = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (roll_w[t] && !empty_w[t] && !rb_we) begin
        pop_w[t] = 1'b1;
        rb_we    = 1'b1;
        rb_entry = top_w[t];
      end
    end
  end

  assign st_we     = accept && !(|ovf_d);
  assign mem_we    = rb_we | st_we;
  assign mem_waddr = rb_we ? rb_entry[EW-1:DW] : st_addr;
  assign mem_wdata = rb_we ? rb_entry[DW-1:0]  : st_data;

  txlog_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (st_addr),
    .rdata_a (old_word),
    .raddr_b (ld_addr),
    .rdata_b (ld_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= ovf_d;
  end

  assign tx_open    = open_w;
  assign rolling    = roll_w;
  assign abort_done = done_w;
  assign overflow   = ovf_q;
endmodule

// File: rtl/txlog_ctrl_chk.sv
module txlog_ctrl_chk #(
  parameter int unsigned NTHR = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            st_ready,
  input logic [NTHR-1:0] tx_open,
  input logic [NTHR-1:0] rolling,
  input logic [NTHR-1:0] abort_done,
  input logic [NTHR-1:0] overflow,
  input logic            rb_we,
  input logic            st_we
);
  p_ready_low_in_roll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rolling) |-> !st_ready);

  p_rollback_excl_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_we |-> !st_we);

  for (genvar t = 0; t < NTHR; t++) begin : g_chk
    p_roll_keeps_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rolling[t] |-> tx_open[t]);

    p_done_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      abort_done[t] |-> (!tx_open[t] && !rolling[t]));

    p_done_after_roll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      abort_done[t] |-> $past(rolling[t]));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      abort_done[t] |=> !abort_done[t]);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow[t] |-> rolling[t]);
  end
endmodule

bind txlog_ctrl txlog_ctrl_chk #(.NTHR(NTHR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_ready   (st_ready),
  .tx_open    (tx_open),
  .rolling    (rolling),
  .abort_done (abort_done),
  .overflow   (overflow),
  .rb_we      (rb_we),
  .st_we      (st_we)
);

// File: tb/sim_txlog_ctrl.sv
`timescale 1ns/1ps
module sim_txlog_ctrl;
  localparam int NT = 2, AW = 4, DW = 8, DEPTH = 4, NMAX = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, st_ready;
  logic [0:0] st_tid = '0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0, ld_data;
  logic [NT-1:0] tx_begin = '0, tx_commit = '0, sw_abort = '0, hw_abort = '0;
  logic [NT-1:0] tx_open, rolling, abort_done, overflow;

  always #2 clk = ~clk;   // 250 MHz

  txlog_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_tid(st_tid), .st_addr(st_addr), .st_data(st_data),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .tx_begin(tx_begin), .tx_commit(tx_commit), .sw_abort(sw_abort), .hw_abort(hw_abort),
    .tx_open(tx_open), .rolling(rolling), .abort_done(abort_done), .overflow(overflow)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
  ent_t lq0[$], lq1[$];
  logic [DW-1:0] m_mem [16];
  bit m_open[NT], m_roll[NT], m_done[NT], m_ovf[NT];
  int m_nest[NT];
  bit pr_open[NT], pr_roll[NT];
  int pr_sz[NT];

  function automatic int qsize(input int t);
    return (t == 0) ? lq0.size() : lq1.size();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      for (int t = 0; t < NT; t++) begin
        m_open[t] = 0; m_roll[t] = 0; m_done[t] = 0; m_ovf[t] = 0; m_nest[t] = 0;
      end
      lq0.delete(); lq1.delete();
    end else begin
      bit anyr;
      int g;
      ent_t e;
      anyr = 0; g = -1;
      for (int t = 0; t < NT; t++) begin
        pr_open[t] = m_open[t]; pr_roll[t] = m_roll[t]; pr_sz[t] = qsize(t);
        anyr |= m_roll[t];
        m_done[t] = pr_roll[t] && pr_sz[t] == 0;
        m_ovf[t] = 0;
      end
      for (int t = NT - 1; t >= 0; t--) if (pr_roll[t] && pr_sz[t] > 0) g = t;
      if (g == 0) begin e = lq0.pop_back(); m_mem[e.a] = e.d; end
      if (g == 1) begin e = lq1.pop_back(); m_mem[e.a] = e.d; end
      if (st_valid && !anyr) begin
        int tt;
        tt = int'(st_tid);
        if (pr_open[tt]) begin
          if (pr_sz[tt] == DEPTH) m_ovf[tt] = 1;
          else begin
            e.a = st_addr; e.d = m_mem[st_addr];
            if (tt == 0) lq0.push_back(e); else lq1.push_back(e);
            m_mem[st_addr] = st_data;
          end
        end else m_mem[st_addr] = st_data;
      end
      for (int t = 0; t < NT; t++) begin
        if (pr_roll[t]) begin
          if (m_done[t]) begin m_roll[t] = 0; m_open[t] = 0; m_nest[t] = 0; end
        end else if (pr_open[t] && (sw_abort[t] || hw_abort[t] || m_ovf[t])) begin
          m_roll[t] = 1;
        end else if (pr_open[t] && tx_commit[t]) begin
          if (m_nest[t] > 0) m_nest[t]--;
          else begin
            m_open[t] = 0;
            if (t == 0) lq0.delete(); else lq1.delete();
          end
        end else if (tx_begin[t]) begin
          if (pr_open[t]) begin if (m_nest[t] < NMAX) m_nest[t]++; end
          else m_open[t] = 1;
        end
      end
    end
  end

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit anyr;
      anyr = m_roll[0] | m_roll[1];
      chk("R8 st_ready", st_ready, !anyr);
      for (int t = 0; t < NT; t++) begin
        chk("R2 tx_open", tx_open[t], m_open[t]);
        chk("R4 rolling", rolling[t], m_roll[t]);
        chk("R4 abort_done", abort_done[t], m_done[t]);
        chk("R7 overflow", overflow[t], m_ovf[t]);
      end
      chk("R3 ld_data", ld_data, m_mem[ld_addr]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input logic [1:0] bg, input logic [1:0] cm, input logic [1:0] sa,
                      input logic [1:0] ha, input logic sv, input logic t,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); #1;
    tx_begin = bg; tx_commit = cm; sw_abort = sa; hw_abort = ha;
    st_valid = sv; st_tid = t; st_addr = a; st_data = d;
  endtask

  task automatic idle();
    tick(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic store(input logic t, input logic [AW-1:0] a, input logic [DW-1:0] d);
    tick(0, 0, 0, 0, 1, t, a, d);
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
    idle();
    ld_addr = a; #1; v = ld_data;
  endtask

  task automatic quiet();
    for (int i = 0; i < 64; i++) begin
      idle();
      if (!(m_roll[0] | m_roll[1] | m_done[0] | m_done[1])) break;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    #1;
    // R11
    chk("R11 st_ready", st_ready, 1);
    chk("R11 tx_open", tx_open, 0);
    chk("R11 rolling", rolling, 0);
    peek(0, v); chk("R11 mem zero", v, 0);

    // R1: plain store
    store(0, 3, 8'h11); peek(3, v); chk("R1 plain store", v, 8'h11);

    // R2/R3/R5/R4
    tick(2'b01, 0, 0, 0, 0, 0, 0, 0); idle();
    chk("R2 begin opens", tx_open, 2'b01);
    store(0, 3, 8'h22); store(0, 3, 8'h33); store(0, 5, 8'h44);
    peek(3, v); chk("R3 tx store visible", v, 8'h33);
    tick(0, 0, 2'b01, 0, 0, 0, 0, 0); idle();
    chk("R4 rolling after abort", rolling, 2'b01);
    chk("R8 ready low in rollback", st_ready, 0);
    quiet();
    peek(3, v); chk("R5 oldest restored", v, 8'h11);
    peek(5, v); chk("R4 restored", v, 8'h00);
    chk("R4 closed after abort", tx_open, 0);

    // R6: independent logs
    tick(2'b11, 0, 0, 0, 0, 0, 0, 0);
    store(0, 1, 8'h0A); store(1, 2, 8'h0B);
    tick(0, 0, 0, 2'b10, 0, 0, 0, 0); quiet();
    peek(2, v); chk("R6 t1 restored", v, 8'h00);
    peek(1, v); chk("R6 t0 kept", v, 8'h0A);
    chk("R6 t0 still open", tx_open, 2'b01);
    tick(0, 2'b01, 0, 0, 0, 0, 0, 0); idle();
    chk("R2 commit closes", tx_open, 0);
    peek(1, v); chk("R2 commit keeps data", v, 8'h0A);

    // R9: nesting
    tick(2'b01, 0, 0, 0, 0, 0, 0, 0); tick(2'b01, 0, 0, 0, 0, 0, 0, 0);
    store(0, 6, 8'h07);
    tick(0, 2'b01, 0, 0, 0, 0, 0, 0); idle();
    chk("R9 inner commit keeps open", tx_open, 2'b01);
    tick(0, 2'b01, 0, 0, 0, 0, 0, 0); idle();
    chk("R9 outer commit closes", tx_open, 0);
    tick(2'b01, 0, 0, 0, 0, 0, 0, 0); tick(2'b01, 0, 0, 0, 0, 0, 0, 0);
    store(0, 6, 8'h09);
    tick(0, 0, 2'b01, 0, 0, 0, 0, 0); quiet();
    peek(6, v); chk("R9 nested abort restores", v, 8'h07);
    chk("R9 nested abort closes", tx_open, 0);

    // R7: overflow
    tick(2'b10, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) store(1, AW'(8 + i), DW'(i + 1));
    idle();
    chk("R7 overflow pulse", overflow, 2'b10);
    chk("R7 forced rollback", rolling, 2'b10);
    quiet();
    peek(12, v); chk("R7 dropped store", v, 8'h00);
    peek(8, v);  chk("R7 restored", v, 8'h00);

    // R10: ignored strobes
    tick(0, 2'b01, 2'b01, 0, 0, 0, 0, 0); idle();
    chk("R10 abort on closed", rolling, 0);
    chk("R10 commit on closed", tx_open, 0);
    tick(2'b01, 0, 0, 0, 0, 0, 0, 0); store(0, 4, 8'h55);
    tick(0, 2'b01, 2'b01, 0, 0, 0, 0, 0); idle();
    chk("R10 abort beats commit", rolling, 2'b01);
    tick(2'b01, 0, 0, 0, 0, 0, 0, 0);
    quiet();
    chk("R10 begin in rollback ignored", tx_open, 0);
    peek(4, v); chk("R10 abort restored", v, 8'h00);

    // R8: two threads roll back together
    tick(2'b11, 0, 0, 0, 0, 0, 0, 0);
    store(0, 7, 8'hA7); store(1, 9, 8'hB9);
    tick(0, 0, 2'b11, 0, 0, 0, 0, 0); idle();
    chk("R8 both rolling", rolling, 2'b11);
    chk("R8 stores stalled", st_ready, 0);
    quiet();
    peek(7, v); chk("R8 t0 restored", v, 8'h00);
    peek(9, v); chk("R8 t1 restored", v, 8'h00);

    // mixed random traffic, checked by the model every clock
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] bg, cm, sa, ha;
      bg = {($urandom % 12) == 0, ($urandom % 12) == 0};
      cm = {($urandom % 14) == 0, ($urandom % 14) == 0};
      sa = {($urandom % 40) == 0, ($urandom % 40) == 0};
      ha = {($urandom % 60) == 0, ($urandom % 60) == 0};
      tick(bg, cm, sa, ha, ($urandom % 2) == 0, 1'($urandom), AW'($urandom), DW'($urandom));
      ld_addr = AW'($urandom);
    end
    quiet();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule